// File: doc/BRIEF.md
# Elliptic Curve Scalar-Multiply Sequencer

This block controls the scalar multiplication Q = kP for a separate point-arithmetic unit. It does no field arithmetic itself. When started, it latches an m-bit scalar and a mode select. It first tells the point unit to load the base point into its accumulator. It then walks the scalar from bit m-2 down to bit 0. For each bit it issues a point-doubling command, and it may follow that with a point-addition command.

Commands go out on a valid/acknowledge port. A command stays presented until the point unit acknowledges it. The scalar's top bit must be 1; a start with that bit clear is refused and flagged.

Two modes are available:
- In plain mode, an addition is issued only for set bits. The command stream therefore reveals the key.
- In uniform mode, an addition follows every doubling. A keep flag tells the point unit whether to write the sum back. The command stream is then the same for every key.

Top module: `ec_smul_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o and cmd_valid_o are all 0.
- R2: A start_i sampled while idle with scalar_i[m-1]=1 makes busy_o=1 in the next cycle, and presents a load command (cmd_op_o=2'b00, cmd_keep_o=1).
- R3: A start_i sampled while idle with scalar_i[m-1]=0 sets err_o in the next cycle, leaves busy_o and cmd_valid_o at 0, and issues no command. err_o stays high until the next start_i sampled while idle, which then sets err_o to the state of that start's top scalar bit being 0.
- R4: A command completes in a cycle where cmd_valid_o and cmd_ack_i are both 1. Until then, cmd_valid_o, cmd_op_o and cmd_keep_o stay unchanged.
- R5: For each bit index i from m-2 down to 0, exactly one doubling command is issued (cmd_op_o=2'b01, cmd_keep_o=1), in that order, after the load.
- R6: In plain mode (uniform_i=0 at start), an addition command (cmd_op_o=2'b10, cmd_keep_o=1) directly follows the doubling for bit i only if bit i is 1.
- R7: In uniform mode (uniform_i=1 at start), an addition follows every doubling, with cmd_keep_o equal to bit i. Each run then issues exactly 2m-1 commands in a fixed pattern: load, then alternating doubling and addition.
- R8: busy_o stays 1 from the cycle after an accepted start through the done_o cycle, and is 0 in the cycle after. done_o is a one-cycle pulse in the cycle after the final command is acknowledged.
- R9: While busy_o=1, start_i, scalar_i and uniform_i are ignored, and the run continues with the values latched at start.
- R10: When the point unit applies load as Q=P, doubling as Q=2Q and a kept addition as Q=Q+P, Q equals kP at done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| uniform_i | input | 1 | 1 selects the key-independent command pattern |
| scalar_i | input | KEY_W | Scalar k; the top bit must be 1 |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last start was refused (top bit 0) |
| cmd_valid_o | output | 1 | Command presented |
| cmd_op_o | output | 2 | 00 load P, 01 double, 10 add P |
| cmd_keep_o | output | 1 | Point unit writes the result back |
| cmd_ack_i | input | 1 | Point unit accepts the command |

## Verification
The handshake assertions assume that the point unit raises cmd_ack_i only while a command is presented. They also assume the unit never needs a command withdrawn. The bench's point-unit model respects both: it acknowledges only a visible command, with a delay of zero to two cycles, and drops the acknowledge after each handshake. The bench sweeps every scalar that has the top bit set, in both modes. On some runs it changes scalar_i and uniform_i, and pulses start_i, while the block is busy. It also issues starts with the top bit clear to exercise refusal.

// File: rtl/ec_smul_pkg.sv
package ec_smul_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_DBL  = 2'b01,
    OP_ADD  = 2'b10
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DBL,
    ST_ADD,
    ST_FIN
  } st_e;
endpackage

// File: rtl/ec_smul_scalar_reg.sv
module ec_smul_scalar_reg #(
  parameter int KEY_W = 8,
  localparam int IDX_W = $clog2(KEY_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [KEY_W-1:0] scalar_i,
  input  logic             uniform_i,
  output logic             bit_o,
  output logic             last_o,
  output logic             uniform_o
);
  logic [KEY_W-1:0] key_q;
  logic [IDX_W-1:0] idx_q;
  logic             uni_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      idx_q <= '0;
      uni_q <= 1'b0;
    end else if (load_i) begin
      key_q <= scalar_i;
      idx_q <= IDX_W'(KEY_W - 2);
      uni_q <= uniform_i;
    end else if (step_i) begin
      idx_q <= idx_q - 1'b1;
    end
  end

  assign bit_o     = key_q[idx_q];
  assign last_o    = (idx_q == '0);
  assign uniform_o = uni_q;

  // index walks down by one, never wraps below zero
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i |=> idx_q == $past(idx_q) - 1'b1) else $error("idx step"); // R5
  AST_IDX_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o) else $error("idx wrap"); // R5
endmodule

// File: rtl/ec_smul_ctrl.sv
module ec_smul_ctrl
  import ec_smul_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic msb_i,
  input  logic hs_i,
  input  logic bit_i,
  input  logic last_i,
  input  logic uniform_i,
  output st_e  state_o,
  output logic load_o,
  output logic step_o,
  output logic err_o
);
  st_e  st_q, st_d;
  logic err_q;
  logic want_add;

  assign want_add = bit_i | uniform_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_i && msb_i) st_d = ST_LOAD;
      ST_LOAD: if (hs_i) st_d = ST_DBL;
      ST_DBL:  if (hs_i) st_d = want_add ? ST_ADD : (last_i ? ST_FIN : ST_DBL);
      ST_ADD:  if (hs_i) st_d = last_i ? ST_FIN : ST_DBL;
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign load_o = (st_q == ST_IDLE) && start_i && msb_i;
  assign step_o = hs_i && !last_i &&
                  ((st_q == ST_DBL && !want_add) || st_q == ST_ADD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      err_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && start_i) err_q <= !msb_i;
    end
  end

  assign state_o = st_q;
  assign err_o   = err_q;

  AST_UNI_ADD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DBL && hs_i && uniform_i |=> st_q == ST_ADD) else $error("uniform add"); // R7
  AST_PLAIN_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_DBL && hs_i && !uniform_i && !bit_i |=> st_q != ST_ADD) else $error("plain skip"); // R6
endmodule

// File: rtl/ec_smul_cmd_enc.sv
module ec_smul_cmd_enc
  import ec_smul_pkg::*;
(
  input  st_e        state_i,
  input  logic       bit_i,
  output logic       valid_o,
  output logic [1:0] op_o,
  output logic       keep_o,
  output logic       busy_o,
  output logic       done_o
);
  always_comb begin
    valid_o = 1'b0;
    op_o    = OP_LOAD;
    keep_o  = 1'b1;
    unique case (state_i)
      ST_LOAD: valid_o = 1'b1;
      ST_DBL:  begin valid_o = 1'b1; op_o = OP_DBL; end
      ST_ADD:  begin valid_o = 1'b1; op_o = OP_ADD; keep_o = bit_i; end
      default: ;
    endcase
  end

  assign busy_o = (state_i != ST_IDLE);
  assign done_o = (state_i == ST_FIN);
endmodule

// File: rtl/ec_smul_seq.sv
module ec_smul_seq
  import ec_smul_pkg::*;
#(
  parameter int KEY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             uniform_i,
  input  logic [KEY_W-1:0] scalar_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cmd_valid_o,
  output logic [1:0]       cmd_op_o,
  output logic             cmd_keep_o,
  input  logic             cmd_ack_i
);
  st_e  state;
  logic load, step, hs, cur_bit, last, uni;

  assign hs = cmd_valid_o && cmd_ack_i;

  ec_smul_scalar_reg #(.KEY_W(KEY_W)) u_scalar (
    .clk_i, .rst_ni,
    .load_i    (load),
    .step_i    (step),
    .scalar_i  (scalar_i),
    .uniform_i (uniform_i),
    .bit_o     (cur_bit),
    .last_o    (last),
    .uniform_o (uni)
  );

  ec_smul_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .start_i   (start_i),
    .msb_i     (scalar_i[KEY_W-1]),
    .hs_i      (hs),
    .bit_i     (cur_bit),
    .last_i    (last),
    .uniform_i (uni),
    .state_o   (state),
    .load_o    (load),
    .step_o    (step),
    .err_o     (err_o)
  );

  ec_smul_cmd_enc u_enc (
    .state_i (state),
    .bit_i   (cur_bit),
    .valid_o (cmd_valid_o),
    .op_o    (cmd_op_o),
    .keep_o  (cmd_keep_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  initial begin
    AST_KEY_W: assert (KEY_W >= 2) else $error("KEY_W too small"); // R5
  end

  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ack_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_keep_o))
    else $error("cmd hold"); // R4
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o) else $error("done pulse"); // R8
  AST_VALID_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> busy_o) else $error("valid busy"); // R8
  AST_REFUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && !scalar_i[KEY_W-1] |=> !busy_o && err_o) else $error("refuse"); // R3
  AST_DONE_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(hs)) else $error("done w/o ack"); // R8
endmodule

// File: tb/ec_smul_seq_bench.sv
module ec_smul_seq_bench;
  localparam int KEY_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, uniform = 1'b0, ack = 1'b0;
  logic [KEY_W-1:0] scalar = '0;
  logic busy, done, err, cvalid, ckeep;
  logic [1:0] cop;

  int n_tests = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  ec_smul_seq #(.KEY_W(KEY_W)) u_ec_smul_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .uniform_i(uniform),
    .scalar_i(scalar), .busy_o(busy), .done_o(done), .err_o(err),
    .cmd_valid_o(cvalid), .cmd_op_o(cop), .cmd_keep_o(ckeep), .cmd_ack_i(ack)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run(input logic [KEY_W-1:0] k, input bit uni, input bit disturb, input int seed);
    longint acc = 0;
    int ncmd = 0, idx = KEY_W - 2, wait_cnt, guard = 0;
    int exp_op = 0;      // 0 load,1 dbl,2 add
    bit exp_keep = 1'b1, seen_done = 1'b0, pend = 1'b0;
    logic [1:0] hold_op = '0;
    logic hold_keep = 1'b0;
    @(negedge clk);
    start = 1'b1; scalar = k; uniform = uni;
    @(negedge clk);
    start = 1'b0;
    chk(busy && cvalid && cop == 2'b00 && ckeep, "R2 load after start", {cop, busy, cvalid}, 3);
    chk(!err, "R3 err cleared by good start", err, 0);
    if (disturb) begin scalar = ~k; uniform = ~uni; end
    wait_cnt = seed % 3;
    while (!seen_done && guard < 200) begin
      guard++;
      if (done) begin
        seen_done = 1'b1;
        ack = 1'b0;
        chk(busy, "R8 busy in done cycle", busy, 1);
        chk(acc == longint'(k), "R10 multiple equals k", acc, k);
        if (uni) chk(ncmd == 2*KEY_W - 1, "R7 uniform command count", ncmd, 2*KEY_W - 1);
        else chk(ncmd == KEY_W + $countones(k[KEY_W-2:0]), "R6 plain command count",
                 ncmd, KEY_W + $countones(k[KEY_W-2:0]));
      end else begin
        chk(busy, "R8 busy during run", busy, 1);
        if (disturb && guard == 3) start = 1'b1;
        if (disturb && guard == 4) start = 1'b0;
        if (ack) begin
          ack = 1'b0; pend = 1'b0;
          wait_cnt = (seed + ncmd) % 3;
        end else if (cvalid) begin
          if (pend) chk(cop == hold_op && ckeep == hold_keep, "R4 command held",
                        {cop, ckeep}, {hold_op, hold_keep});
          pend = 1'b1; hold_op = cop; hold_keep = ckeep;
          if (wait_cnt > 0) wait_cnt--;
          else begin
            chk(int'(cop) == exp_op && ckeep == exp_keep,
                exp_op == 2 ? (uni ? "R7 add order/keep" : "R6 add order") : "R5 op order",
                {cop, ckeep}, {exp_op[1:0], exp_keep});
            case (cop)
              2'b00: acc = 1;
              2'b01: acc = acc * 2;
              2'b10: if (ckeep) acc = acc + 1;
              default: ;
            endcase
            ncmd++;
            // next expected command
            if (exp_op == 0) begin exp_op = 1; exp_keep = 1'b1; end
            else if (exp_op == 1 && (uni || k[idx])) begin exp_op = 2; exp_keep = k[idx]; end
            else begin idx--; exp_op = 1; exp_keep = 1'b1; end
            ack = 1'b1;
          end
        end
      end
      @(negedge clk);
    end
    chk(seen_done, "R8 done reached", seen_done, 1);
    chk(!done && !busy && !cvalid, "R8 done one cycle then idle", {done, busy}, 0);
    scalar = '0; uniform = 1'b0;
  endtask

  task automatic refuse(input logic [KEY_W-1:0] k);
    @(negedge clk);
    start = 1'b1; scalar = k;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && !cvalid, "R3 refused start", {err, busy, cvalid}, 4);
    repeat (2) @(negedge clk);
    chk(err && !busy && !cvalid, "R3 err held, no command", {err, busy, cvalid}, 4);
  endtask

  initial begin
    int seed = 0;
    #1;
    chk(!busy && !done && !err && !cvalid, "R1 reset outputs", {busy, done, err, cvalid}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!busy && !done && !err && !cvalid, "R1 after reset", {busy, done, err, cvalid}, 0);
    refuse('0);
    refuse(8'h7f);
    for (int u = 0; u < 2; u++) begin
      for (int k = 1 << (KEY_W-1); k < (1 << KEY_W); k++) begin
        run(KEY_W'(k), bit'(u), (k % 5) == 0, seed);  // R9 on disturbed runs
        seed++;
        if ((k % 37) == 0) refuse(KEY_W'(k) & ~(KEY_W'(1) << (KEY_W-1)));
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule